// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block keeps the 32-bit control and status word that gathers completion events from seven DMA channels into a single interrupt toward the system interrupt controller. Software uses CPU writes to program per-channel enables, a global enable and a force bit. Completion pulses from the channels latch per-channel flags. Software clears those flags by writing ones to them.

A summary (master) flag in bit 31 is worked out again after every write and after every completion pulse. The block emits a one-cycle request pulse only when that flag goes from clear to set. A flag that is already set does not produce a second request. The full word is always visible on the read port.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `rd_data` is 0 and `irq_pulse` is 0.
- R2: On a write, the bits selected by mask 0x00FF803F take the written value. Bits 5..0 and 15 are single controls, bits 22..16 enable channels 0..6, and bit 23 is the global enable.
- R3: On a write, each flag in bits 30..24 stays set only if it was set and the written bit at the same position is 0. A written 1 clears it, and a write never sets a flag.
- R4: After any cycle that has a write or a completion pulse, bit 31 equals bit 15 OR (bit 23 AND any of bits 30..24), taken on the updated register.
- R5: `irq_pulse` is high for exactly one cycle, in the cycle after the update edge at which bit 31 went from 0 to 1. If bit 31 was already 1, no pulse is produced.
- R6: Bits 14..6 always read as 0.
- R7: A pulse on `done[n]` sets flag bit 24+n only if enable bit 16+n was set before that cycle. Otherwise the pulse has no effect on the flags.
- R8: If `done[n]` and a write of 1 to flag bit 24+n happen in the same cycle and the channel is enabled, the flag ends up set.
- R9: In a cycle with no write and no completion pulse, the register does not change and no request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 32 | CPU write value |
| done | input | 7 | Per-channel completion pulses, bit n for channel n |
| rd_data | output | 32 | Current register contents |
| irq_pulse | output | 1 | One-cycle request to the interrupt controller |

## Verification
The hardest state to reach is a completion pulse and a write-one-to-clear of the same flag in the same cycle, with the channel enabled. The state right next to it is also hard: the master flag already set when a further event arrives, so that the request must be withheld. Directed sequences set up the enables first and then line up both events on one edge. Random stimulus keeps writes and pulses sparse and biases the written flag bits toward zero. This lets flags build up, so the master flag stays set across many events and is then cleared and raised again.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [6:0]  done,
  output logic [31:0] rd_data,
  output logic        irq_pulse
);
  localparam logic [31:0] PLAIN_MASK = 32'h00FF_803F;

  logic [31:0] ctl_q, ctl_d;
  logic        irq_q;
  logic        event_any;

  assign event_any = wr_en | (|done);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en)
      ctl_d = (wr_data & PLAIN_MASK) | {1'b0, ctl_q[30:24] & ~wr_data[30:24], 24'd0};
    ctl_d[30:24] = ctl_d[30:24] | (done & ctl_q[22:16]);
    if (event_any)
      ctl_d[31] = ctl_d[15] | (ctl_d[23] & (|ctl_d[30:24]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      irq_q <= ctl_d[31] & ~ctl_q[31];
    end
  end

  assign rd_data   = ctl_q;
  assign irq_pulse = irq_q;

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14:6] == 9'd0);

  p_irq_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (rd_data[31] && !$past(rd_data[31])));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_master_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || (|done)) |=> (rd_data[31] == (rd_data[15] | (rd_data[23] & (|rd_data[30:24])))));

  p_flag_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[30:24] & ~$past(rd_data[30:24])) & ~($past(done) & $past(rd_data[22:16]))) == 7'd0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && done == 7'd0) |=> ($stable(rd_data) && !irq_pulse));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  done = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q = '0;
  logic        exp_irq = 1'b0;

  always #4 clk = ~clk;

  dma_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                      .done(done), .rd_data(rd_data), .irq_pulse(irq_pulse));

  function automatic logic [31:0] model_next(logic [31:0] old, logic we,
                                             logic [31:0] wd, logic [6:0] dn);
    logic [31:0] v;
    v = old;
    if (we) begin
      v = wd & 32'h00FF_803F;
      v[30:24] = old[30:24] & ~wd[30:24];
    end
    v[30:24] = v[30:24] | (dn & old[22:16]);
    if (we || dn != 7'd0) v[31] = v[15] | (v[23] & (|v[30:24]));
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2", rd_data & 32'h00FF_803F, exp_q & 32'h00FF_803F);
    check("R3", {25'd0, rd_data[30:24]}, {25'd0, exp_q[30:24]});
    check("R4", {31'd0, rd_data[31]}, {31'd0, exp_q[31]});
    check("R5", {31'd0, irq_pulse}, {31'd0, exp_irq});
    check("R6", {23'd0, rd_data[14:6]}, 32'd0);
  endtask

  task automatic step(logic we, logic [31:0] wd, logic [6:0] dn);
    logic [31:0] nx;
    wr_en = we; wr_data = wd; done = dn;
    nx = model_next(exp_q, we, wd, dn);
    exp_irq = nx[31] & ~exp_q[31];
    exp_q = nx;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; done = '0;
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    check("R1", rd_data, 32'd0);
    check("R1", {31'd0, irq_pulse}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 32'd0);
    check("R1", {31'd0, irq_pulse}, 32'd0);

    // R2: reserved bits dropped, plain bits taken
    step(1'b1, 32'hFFFF_FFFF, 7'd0);
    check("R2", rd_data, 32'h80FF_803F);
    check("R5", {31'd0, irq_pulse}, 32'd1);
    // R5: still set, no new request
    step(1'b1, 32'h0000_8000, 7'd0);
    check("R5", {31'd0, irq_pulse}, 32'd0);
    // R4: force off, master falls
    step(1'b1, 32'h0000_0000, 7'd0);
    check("R4", rd_data, 32'd0);
    // R7: pulse without enable has no effect
    step(1'b0, 32'd0, 7'h7F);
    check("R7", rd_data, 32'd0);
    // R7: enable ch0 and ch3, global enable
    step(1'b1, 32'h0089_0000, 7'd0);
    step(1'b0, 32'd0, 7'h09);
    check("R7", rd_data, 32'h8989_0000);
    check("R5", {31'd0, irq_pulse}, 32'd1);
    // R8: completion wins over clear of ch0
    step(1'b1, 32'h0189_0000, 7'h01);
    check("R8", {31'd0, rd_data[24]}, 32'd1);
    check("R3", {31'd0, rd_data[27]}, 32'd1);
    // R3: clear ch3, ch0 flag stays
    step(1'b1, 32'h0889_0000, 7'd0);
    check("R3", rd_data, 32'h8189_0000);
    // R9: idle cycles
    step(1'b0, 32'd0, 7'd0);
    check("R9", rd_data, 32'h8189_0000);
    check("R9", {31'd0, irq_pulse}, 32'd0);
    // R4: global enable off with flag set -> master cleared
    step(1'b1, 32'h0009_0000, 7'd0);
    check("R4", rd_data, 32'h0109_0000);

    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [31:0] wd;
      logic [6:0] dn;
      we = ($urandom % 4) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[30:24] = 7'd0;
      if (($urandom % 2) == 0) wd[15] = 1'b0;
      dn = (($urandom % 3) == 0) ? 7'($urandom) : 7'd0;
      step(we, wd, dn);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule